// File: doc/BRIEF.md
# Burst Framing Controller

This controller frames front-end data-taking around accelerator bursts. It watches two strobes that come from a broadcast timing link. The first is a command strobe that carries a command code. The second is a trigger strobe that carries a trigger type. From these strobes it decides when readout is open. It keeps a free-running timestamp counter that advances once per system clock. It asks the data formatter for one record per accepted physics trigger, and it tags each request with the counter value at the moment the trigger arrived.

Opening and closing each take two steps. A start-of-burst command zeroes the counter and arms the controller (transition *arm*). A start-of-burst trigger then opens readout (transition *open*). An end-of-burst command latches the counter into a holding register and moves to the closing phase (transition *stamp*). Readout stays open in that phase. An end-of-burst trigger raises a summary-record request and returns to idle (transition *close*). If the end-of-burst trigger arrives straight from the taking phase (transition *close-unstamped*), the burst still closes, but a flag records that no end timestamp was taken. A start-of-burst command that arrives in any phase other than idle causes a restart (transition *restart*): the counter clears, an error flag is raised and the controller returns to armed. The four phases are IDLE, ARMED, TAKING and CLOSING. Every output is registered and changes one clock after the strobe that causes it.

Top module: `burst_frame_ctrl`

## Requirements
- R1: After reset the controller is in IDLE, with phase encoded as IDLE=0, ARMED=1, TAKING=2 and CLOSING=3. All other outputs read zero and the timestamp counter is zero.
- R2: The timestamp counter advances by one on every clock, modulo 2^TS_W. A start-of-burst command in any phase sets it to zero at the next edge.
- R3: A start-of-burst command (code 1) in IDLE moves to ARMED. It also clears the stray-trigger count, the missing-stamp flag and the restart flag.
- R4: A start-of-burst trigger (type 1) in ARMED moves to TAKING. In any other phase it has no effect.
- R5: A physics trigger in TAKING or CLOSING gives a one-clock send_valid pulse on the next clock. In that cycle send_tag holds the counter value from the cycle in which the trigger was sampled. send_tag keeps that value until the next accepted trigger.
- R6: A physics trigger in IDLE or ARMED produces no send_valid. It increments stray_count, which saturates at 2^ERR_W-1.
- R7: An end-of-burst command (code 2) in TAKING loads the current counter value into eob_stamp and moves to CLOSING. In every other phase it leaves eob_stamp and the phase unchanged.
- R8: An end-of-burst trigger (type 2) in TAKING or CLOSING gives a one-clock eob_req pulse on the next clock and moves to IDLE. In IDLE or ARMED it is ignored.
- R9: An end-of-burst trigger taken directly from TAKING, with no end-of-burst command before it, sets eob_stamp_missing. The flag stays set until the next start-of-burst command in IDLE.
- R10: A start-of-burst command in ARMED, TAKING or CLOSING moves to ARMED, clears the counter and sets restart_err. stray_count is left unchanged.
- R11: Trigger types other than 1 and 2 are physics triggers. Command codes other than 1 and 2 are ignored. A recognised command suppresses any trigger in the same cycle, so that trigger has no effect at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the counter advances once per edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | CMD_W | Command code (1 start of burst, 2 end of burst) |
| trig_valid | input | 1 | Trigger strobe |
| trig_type | input | TYPE_W | Trigger type (1 start of burst, 2 end of burst, others physics) |
| phase | output | 2 | Current phase (IDLE=0, ARMED=1, TAKING=2, CLOSING=3) |
| send_valid | output | 1 | One-clock request to send one event record |
| send_tag | output | TS_W | Timestamp belonging to the last send request |
| eob_stamp | output | TS_W | Counter value latched by the end-of-burst command |
| eob_req | output | 1 | One-clock request to emit the end-of-burst summary record |
| eob_stamp_missing | output | 1 | The burst closed without an end-of-burst command |
| restart_err | output | 1 | The last start-of-burst command interrupted an open burst |
| stray_count | output | ERR_W | Saturating count of physics triggers outside readout |

## Verification
A wrong phase register is visible at the ports on the next trigger: a physics trigger in that cycle gives a send_valid pulse where the stray count should have moved, or the reverse. The phase output also shows the error one clock after the bad transition. An error in the counter appears in send_tag and eob_stamp on the first accepted trigger or stamp after the fault. The reference model in the bench compares every output on every clock, so a divergence is reported within one cycle of becoming visible.

// File: rtl/burst_frame_pkg.sv
package burst_frame_pkg;

    // Command codes carried with the command strobe
    localparam int CODE_SOB = 1;
    localparam int CODE_EOB = 2;
    // Trigger types carried with the trigger strobe; other values are physics
    localparam int TTYPE_SOB = 1;
    localparam int TTYPE_EOB = 2;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ARMED   = 2'd1,
        PH_TAKING  = 2'd2,
        PH_CLOSING = 2'd3
    } phase_t;

    typedef struct packed {
        logic sob_cmd;
        logic eob_cmd;
        logic sob_trig;
        logic eob_trig;
        logic phys_trig;
    } evt_t;

endpackage

// File: rtl/burst_evt_decode.sv
module burst_evt_decode
    import burst_frame_pkg::*;
#(
    parameter int CMD_W  = 4,
    parameter int TYPE_W = 2
) (
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_code,
    input  logic              trig_valid,
    input  logic [TYPE_W-1:0] trig_type,
    output evt_t              evt
);

    logic known_cmd;
    logic trig_ok;

    always_comb begin
        evt.sob_cmd   = cmd_valid && (cmd_code == CMD_W'(CODE_SOB));
        evt.eob_cmd   = cmd_valid && (cmd_code == CMD_W'(CODE_EOB));
        known_cmd     = evt.sob_cmd || evt.eob_cmd;
        // a recognised command wins the cycle over any trigger (R11)
        trig_ok       = trig_valid && !known_cmd;
        evt.sob_trig  = trig_ok && (trig_type == TYPE_W'(TTYPE_SOB));
        evt.eob_trig  = trig_ok && (trig_type == TYPE_W'(TTYPE_EOB));
        evt.phys_trig = trig_ok && !evt.sob_trig && !evt.eob_trig;
    end

endmodule

// File: rtl/burst_ts_counter.sv
module burst_ts_counter #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    output logic [TS_W-1:0] ts
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            ts <= '0;
        else if (clear)
            ts <= '0;
        else
            ts <= ts + TS_W'(1);
    end

endmodule

// File: rtl/burst_phase_fsm.sv
module burst_phase_fsm
    import burst_frame_pkg::*;
#(
    parameter int TS_W  = 32,
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  evt_t             evt,
    input  logic [TS_W-1:0]  ts,
    output phase_t           state_q,
    output logic             send_valid,
    output logic [TS_W-1:0]  send_tag,
    output logic [TS_W-1:0]  eob_stamp,
    output logic             eob_req,
    output logic             stamp_missing,
    output logic             restart_err,
    output logic [ERR_W-1:0] stray_count
);

    phase_t state_d;
    logic   in_burst;
    logic   is_idle;

    assign in_burst = (state_q == PH_TAKING) || (state_q == PH_CLOSING);
    assign is_idle  = (state_q == PH_IDLE);

    // next-phase selection
    always_comb begin
        state_d = state_q;
        if (evt.sob_cmd) begin
            state_d = PH_ARMED;                 // arm or restart
        end else begin
            unique case (state_q)
                PH_IDLE:    state_d = PH_IDLE;
                PH_ARMED:   if (evt.sob_trig) state_d = PH_TAKING;
                PH_TAKING: begin
                    if (evt.eob_cmd)       state_d = PH_CLOSING;
                    else if (evt.eob_trig) state_d = PH_IDLE;
                end
                PH_CLOSING: if (evt.eob_trig) state_d = PH_IDLE;
                default:    state_d = PH_IDLE;
            endcase
        end
    end

    // phase register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= PH_IDLE;
        else
            state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            send_valid    <= 1'b0;
            send_tag      <= '0;
            eob_stamp     <= '0;
            eob_req       <= 1'b0;
            stamp_missing <= 1'b0;
            restart_err   <= 1'b0;
            stray_count   <= '0;
        end else begin
            send_valid <= in_burst && evt.phys_trig;
            if (in_burst && evt.phys_trig)
                send_tag <= ts;
            eob_req <= in_burst && evt.eob_trig;
            if ((state_q == PH_TAKING) && evt.eob_cmd)
                eob_stamp <= ts;
            if (evt.sob_cmd && is_idle)
                stamp_missing <= 1'b0;
            else if ((state_q == PH_TAKING) && evt.eob_trig)
                stamp_missing <= 1'b1;
            if (evt.sob_cmd)
                restart_err <= !is_idle;
            if (evt.sob_cmd && is_idle)
                stray_count <= '0;
            else if (!in_burst && evt.phys_trig && (stray_count != '1))
                stray_count <= stray_count + ERR_W'(1);
        end
    end

    AST_SEND_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        send_valid |-> ($past(state_q) == PH_TAKING || $past(state_q) == PH_CLOSING)); // R5
    AST_EOB_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        eob_req |-> (state_q == PH_IDLE)); // R8
    AST_MISSING_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stamp_missing) |-> eob_req); // R9
    AST_RESTART_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(restart_err) |-> (state_q == PH_ARMED)); // R10
    AST_STRAY_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(evt.sob_cmd) |-> (stray_count >= $past(stray_count))); // R6
    AST_STAMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) != PH_TAKING) |-> $stable(eob_stamp)); // R7

endmodule

// File: rtl/burst_frame_ctrl.sv
module burst_frame_ctrl
    import burst_frame_pkg::*;
#(
    parameter int CMD_W  = 4,
    parameter int TYPE_W = 2,
    parameter int TS_W   = 32,
    parameter int ERR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_code,
    input  logic              trig_valid,
    input  logic [TYPE_W-1:0] trig_type,
    output logic [1:0]        phase,
    output logic              send_valid,
    output logic [TS_W-1:0]   send_tag,
    output logic [TS_W-1:0]   eob_stamp,
    output logic              eob_req,
    output logic              eob_stamp_missing,
    output logic              restart_err,
    output logic [ERR_W-1:0]  stray_count
);

    evt_t            evt;
    logic [TS_W-1:0] ts;
    phase_t          cur_phase;

    burst_evt_decode #(.CMD_W(CMD_W), .TYPE_W(TYPE_W)) u_dec (
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .trig_valid (trig_valid),
        .trig_type  (trig_type),
        .evt        (evt)
    );

    burst_ts_counter #(.TS_W(TS_W)) u_ts (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (evt.sob_cmd),
        .ts    (ts)
    );

    burst_phase_fsm #(.TS_W(TS_W), .ERR_W(ERR_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .evt           (evt),
        .ts            (ts),
        .state_q       (cur_phase),
        .send_valid    (send_valid),
        .send_tag      (send_tag),
        .eob_stamp     (eob_stamp),
        .eob_req       (eob_req),
        .stamp_missing (eob_stamp_missing),
        .restart_err   (restart_err),
        .stray_count   (stray_count)
    );

    assign phase = cur_phase;

    AST_SOB_CLEARS_TS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == CMD_W'(CODE_SOB)) |=> (ts == '0)); // R2

endmodule

// File: tb/burst_frame_ctrl_test.sv
module burst_frame_ctrl_test;

    localparam int STRAY_MAX = 255;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_code = '0;
    logic        trig_valid = 1'b0;
    logic [1:0]  trig_type = '0;
    logic [1:0]  phase;
    logic        send_valid;
    logic [31:0] send_tag;
    logic [31:0] eob_stamp;
    logic        eob_req;
    logic        eob_stamp_missing;
    logic        restart_err;
    logic [7:0]  stray_count;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int          m_ph = 0;
    logic [31:0] m_ts = '0;
    logic        e_send = 0;
    logic [31:0] e_tag = '0;
    logic [31:0] e_stamp = '0;
    logic        e_req = 0;
    logic        e_miss = 0;
    logic        e_rst = 0;
    int          e_stray = 0;

    always #10 clk = ~clk;

    burst_frame_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .trig_valid(trig_valid), .trig_type(trig_type), .phase(phase),
        .send_valid(send_valid), .send_tag(send_tag), .eob_stamp(eob_stamp),
        .eob_req(eob_req), .eob_stamp_missing(eob_stamp_missing),
        .restart_err(restart_err), .stray_count(stray_count)
    );

    function automatic int next_phase(int ph, bit sobc, bit eobc, bit sobt, bit eobt);
        if (sobc) return 1;
        case (ph)
            1: return sobt ? 2 : 1;
            2: return eobc ? 3 : (eobt ? 0 : 2);
            3: return eobt ? 0 : 3;
            default: return 0;
        endcase
    endfunction

    function automatic bit open_phase(int ph);
        return (ph == 2) || (ph == 3);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R4 phase", 64'(phase), 64'(m_ph));
        chk("R5 send_valid", 64'(send_valid), 64'(e_send));
        chk("R2 send_tag", 64'(send_tag), 64'(e_tag));
        chk("R7 eob_stamp", 64'(eob_stamp), 64'(e_stamp));
        chk("R8 eob_req", 64'(eob_req), 64'(e_req));
        chk("R9 missing", 64'(eob_stamp_missing), 64'(e_miss));
        chk("R10 restart", 64'(restart_err), 64'(e_rst));
        chk("R6 stray", 64'(stray_count), 64'(e_stray));
    endtask

    // one clock: drive, let the edge pass, update the model, compare at the falling edge
    task automatic step(input bit cv, input logic [3:0] code, input bit tv, input logic [1:0] tt);
        bit sobc, eobc, blk, sobt, eobt, phys, inb;
        cmd_valid = cv; cmd_code = code; trig_valid = tv; trig_type = tt;
        @(posedge clk);
        sobc = cv && code == 4'd1;
        eobc = cv && code == 4'd2;
        blk  = sobc || eobc;
        sobt = tv && !blk && tt == 2'd1;
        eobt = tv && !blk && tt == 2'd2;
        phys = tv && !blk && tt != 2'd1 && tt != 2'd2;
        inb  = open_phase(m_ph);
        e_send = inb && phys;
        if (e_send) e_tag = m_ts;
        e_req = inb && eobt;
        if (m_ph == 2 && eobc) e_stamp = m_ts;
        if (sobc && m_ph == 0) e_miss = 0;
        else if (m_ph == 2 && eobt) e_miss = 1;
        if (sobc) e_rst = (m_ph != 0);
        if (sobc && m_ph == 0) e_stray = 0;
        else if (!inb && phys && e_stray < STRAY_MAX) e_stray++;
        m_ph = next_phase(m_ph, sobc, eobc, sobt, eobt);
        m_ts = sobc ? 32'd0 : m_ts + 32'd1;
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 4'd0, 0, 2'd0);
    endtask

    initial begin
        void'($urandom(32'd424242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 phase", 64'(phase), 64'd0);
        chk("R1 send_valid", 64'(send_valid), 64'd0);
        chk("R1 send_tag", 64'(send_tag), 64'd0);
        chk("R1 eob_stamp", 64'(eob_stamp), 64'd0);
        chk("R1 flags", 64'({eob_req, eob_stamp_missing, restart_err}), 64'd0);
        chk("R1 stray", 64'(stray_count), 64'd0);

        // clean burst
        idle(5);
        step(0, 4'd0, 1, 2'd0);                 // stray in IDLE
        step(1, 4'd1, 0, 2'd0);                 // start-of-burst command
        chk("R3 armed", 64'(phase), 64'd1);
        chk("R3 stray cleared", 64'(stray_count), 64'd0);
        idle(3);
        step(0, 4'd0, 1, 2'd3);                 // physics while ARMED: stray
        step(0, 4'd0, 1, 2'd1);                 // start-of-burst trigger
        chk("R4 taking", 64'(phase), 64'd2);
        idle(2);
        step(0, 4'd0, 1, 2'd0);                 // counter was 7 here
        chk("R5 send pulse", 64'(send_valid), 64'd1);
        chk("R5 tag value", 64'(send_tag), 64'd7);
        step(0, 4'd0, 0, 2'd0);
        chk("R5 pulse one clock", 64'(send_valid), 64'd0);
        step(1, 4'd2, 0, 2'd0);                 // end-of-burst command, counter 9
        chk("R7 stamp", 64'(eob_stamp), 64'd9);
        step(0, 4'd0, 1, 2'd3);                 // still sends in CLOSING
        step(1, 4'd2, 0, 2'd0);                 // second stamp ignored
        chk("R7 second stamp ignored", 64'(eob_stamp), 64'd9);
        step(0, 4'd0, 1, 2'd2);                 // end-of-burst trigger
        chk("R8 eob_req", 64'(eob_req), 64'd1);
        chk("R9 stamped close", 64'(eob_stamp_missing), 64'd0);
        step(0, 4'd0, 1, 2'd0);                 // after close: stray
        chk("R8 readout closed", 64'(send_valid), 64'd0);

        // close without stamp
        step(1, 4'd1, 0, 2'd0);
        step(0, 4'd0, 1, 2'd1);
        idle(4);
        step(0, 4'd0, 1, 2'd2);
        chk("R9 missing set", 64'(eob_stamp_missing), 64'd1);
        idle(2);

        // restart during burst, and priority rules
        step(1, 4'd1, 0, 2'd0);
        step(0, 4'd0, 1, 2'd1);
        idle(3);
        step(1, 4'd2, 1, 2'd0);                 // stamp command hides the trigger
        chk("R11 trigger suppressed", 64'(send_valid), 64'd0);
        step(1, 4'd5, 1, 2'd0);                 // unknown code: trigger stands
        chk("R11 unknown code ignored", 64'(send_valid), 64'd1);
        step(1, 4'd1, 1, 2'd2);                 // restart; trigger suppressed
        chk("R10 restart flag", 64'(restart_err), 64'd1);
        chk("R10 back to armed", 64'(phase), 64'd1);
        chk("R11 no eob_req", 64'(eob_req), 64'd0);
        step(0, 4'd0, 1, 2'd1);
        step(0, 4'd0, 1, 2'd0);                 // counter cleared at restart -> 1
        chk("R2 counter restarted", 64'(send_tag), 64'd1);
        step(0, 4'd0, 1, 2'd2);
        idle(2);

        // stray saturation
        for (int i = 0; i < 260; i++) step(0, 4'd0, 1, 2'd3);
        chk("R6 saturated", 64'(stray_count), 64'(STRAY_MAX));

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            bit cv, tv;
            logic [3:0] code;
            logic [1:0] tt;
            cv   = ($urandom % 10) == 0;
            code = 4'($urandom % 4);
            tv   = ($urandom % 3) == 0;
            tt   = 2'($urandom % 4);
            step(cv, code, tv, tt);
        end

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule